// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block walks the translation tables when the TLB misses. A walk starts from a 32-bit virtual address, an 8-bit context number and the context-table pointer register. The walker reads one 32-bit word at a time over a request/acknowledge memory port. It follows table descriptors downward until it finds a page table entry, meets a bad descriptor, or receives a bus error. A walk can end at any of four depths: the context table, the region table (level 1), the segment table (level 2) or the page table (level 3).

At the end of a walk the block returns several results: the physical address, which is merged from the entry and the virtual address according to the depth reached; the entry fields needed to fill a TLB line; the level code; and a fault code. A one-cycle done pulse marks the result. The result then stays on the outputs until a later walk finishes. The block does not hold TLB storage and does not write updated reference or modified bits back to memory.

Top module: `table_walker`

## Requirements
- R1: After reset, busy, done and memReq are 0, fault reads 000 and level reads 00.
- R2: A start while idle makes memReq rise on the next cycle. The first address is {ctxPtr[31:2],2'b00} + ctxNum*4. While memAck is low, memReq stays high and memAddr is held.
- R3: A fetched word is decoded by bits 1:0 (00 invalid, 01 table descriptor, 10 page table entry, 11 reserved). A table descriptor read at depth d sends the next read to {word[31:2],2'b00} + index*4. The index is vaddr[31:24] after the context read, vaddr[23:18] after level 1, and vaddr[17:12] after level 2.
- R4: For a successful walk, physAddr depends on the depth where the entry was found:
  - context depth: physAddr = vaddr.
  - level 1: physAddr = {pte[27:20], vaddr[23:0]}.
  - level 2: physAddr = {pte[27:14], vaddr[17:0]}.
  - level 3: physAddr = {pte[27:8], vaddr[11:0]}.
- R5: level reports the depth of the last word read: 00 context, 01 level 1, 10 level 2, 11 level 3.
- R6: On success the outputs are fault 000, ppn = pte[31:8], cacheable = pte[7], acc = pte[4:2], referenced = 1, and modified = pte[6] OR isStore (isStore as captured at start).
- R7: An invalid descriptor (bits 1:0 = 00) ends the walk with fault 001.
- R8: A reserved descriptor (11), or a table descriptor (01) read at level 3, ends the walk with fault 110.
- R9: memErr together with memAck ends the walk with fault 101, whatever the data.
- R10: A start during a walk is ignored. done is high for exactly one cycle, the cycle after the final acknowledge. The results hold until the next walk ends.
- R11: A faulting walk returns physAddr, ppn, cacheable, modified, referenced and acc all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| ctxNum | input | 8 | Current context number |
| ctxPtr | input | 32 | Context table pointer register (bits 31:2 used) |
| isStore | input | 1 | The missing access is a store |
| memReq | output | 1 | Read request, held until acknowledged |
| memAddr | output | 32 | Word address of the read |
| memAck | input | 1 | Read response valid |
| memErr | input | 1 | Response carries a bus error |
| memData | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| physAddr | output | 32 | Translated physical address |
| ppn | output | 24 | Entry physical page number |
| cacheable | output | 1 | Entry cacheable bit |
| modified | output | 1 | Modified bit for the TLB fill |
| referenced | output | 1 | Referenced bit for the TLB fill |
| acc | output | 3 | Entry access permission field |
| level | output | 2 | Depth the walk reached |
| fault | output | 3 | Fault code |

## Verification
The hardest case to reach is a walk that ends deep in the table, and in particular a table descriptor that shows up at level 3. That case needs three consistent descriptors in a row, each pointing where the next read is expected. The bench acts as the memory. For every ending depth and every kind of final word, it builds the descriptor chain on the fly and checks each read address against the arithmetic of the index fields. It also varies the response latency and, while a read is pending, fires a stray start to show that it is ignored.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int ADDR_W = 32;

  localparam logic [1:0] ET_INV = 2'b00;
  localparam logic [1:0] ET_PTD = 2'b01;
  localparam logic [1:0] ET_PTE = 2'b10;
  localparam logic [1:0] ET_RSV = 2'b11;

  localparam logic [1:0] LVL_CTX = 2'b00;
  localparam logic [1:0] LVL_L1  = 2'b01;
  localparam logic [1:0] LVL_L2  = 2'b10;
  localparam logic [1:0] LVL_L3  = 2'b11;

  localparam logic [2:0] FT_NONE  = 3'b000;
  localparam logic [2:0] FT_INV   = 3'b001;
  localparam logic [2:0] FT_BUS   = 3'b101;
  localparam logic [2:0] FT_TRANS = 3'b110;

  typedef struct packed {
    logic       capture;
    logic       descend;
    logic       takePte;
    logic       takeFault;
    logic [2:0] faultCode;
  } walkStrobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        memAck,
  input  logic        memErr,
  input  logic [1:0]  descType,
  input  logic [1:0]  curLvl,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        busy
);
  typedef enum logic {S_IDLE, S_FETCH} state_t;
  state_t state, stateNext;

  always_comb begin
    strobe = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateNext = S_FETCH;
        end
      end
      S_FETCH: begin
        if (memAck) begin
          if (memErr) begin
            strobe.takeFault = 1'b1;
            strobe.faultCode = FT_BUS;
          end else begin
            case (descType)
              ET_INV: begin
                strobe.takeFault = 1'b1;
                strobe.faultCode = FT_INV;
              end
              ET_RSV: begin
                strobe.takeFault = 1'b1;
                strobe.faultCode = FT_TRANS;
              end
              ET_PTD: begin
                if (curLvl == LVL_L3) begin
                  strobe.takeFault = 1'b1;
                  strobe.faultCode = FT_TRANS;
                end else begin
                  strobe.descend = 1'b1;
                end
              end
              default: strobe.takePte = 1'b1;
            endcase
          end
          if (strobe.takeFault || strobe.takePte) stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNext;
  end

  assign memReq = (state == S_FETCH);
  assign busy   = (state == S_FETCH);
endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [CTX_W-1:0]  ctxNum,
  input  logic [ADDR_W-1:0] ctxPtr,
  input  logic              isStore,
  input  logic [ADDR_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        curLvl,
  output logic              done,
  output logic [ADDR_W-1:0] physAddr,
  output logic [23:0]       ppn,
  output logic              cacheable,
  output logic              modified,
  output logic              referenced,
  output logic [2:0]        acc,
  output logic [1:0]        level,
  output logic [2:0]        fault
);
  localparam int CTX_PAD = ADDR_W - CTX_W - 2;
  localparam int IDX_W   = 8;
  localparam int IDX_PAD = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] vaReg, addrReg, startAddr, nextAddr, merged;
  logic [1:0]        lvlReg;
  logic              storeReg;
  logic [IDX_W-1:0]  nextIdx;

  assign startAddr = {ctxPtr[ADDR_W-1:2], 2'b00} + {{CTX_PAD{1'b0}}, ctxNum, 2'b00};

  always_comb begin
    case (lvlReg)
      LVL_CTX: nextIdx = vaReg[31:24];
      LVL_L1:  nextIdx = {2'b00, vaReg[23:18]};
      default: nextIdx = {2'b00, vaReg[17:12]};
    endcase
  end

  assign nextAddr = {memData[ADDR_W-1:2], 2'b00} + {{IDX_PAD{1'b0}}, nextIdx, 2'b00};

  always_comb begin
    case (lvlReg)
      LVL_CTX: merged = vaReg;
      LVL_L1:  merged = {memData[27:20], vaReg[23:0]};
      LVL_L2:  merged = {memData[27:14], vaReg[17:0]};
      default: merged = {memData[27:8],  vaReg[11:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaReg <= '0; addrReg <= '0; lvlReg <= LVL_CTX; storeReg <= 1'b0;
    end else if (strobe.capture) begin
      vaReg <= vaddr; addrReg <= startAddr; lvlReg <= LVL_CTX; storeReg <= isStore;
    end else if (strobe.descend) begin
      addrReg <= nextAddr; lvlReg <= lvlReg + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; physAddr <= '0; ppn <= '0; cacheable <= 1'b0;
      modified <= 1'b0; referenced <= 1'b0; acc <= '0;
      level <= LVL_CTX; fault <= FT_NONE;
    end else begin
      done <= strobe.takePte | strobe.takeFault;
      if (strobe.takePte) begin
        physAddr   <= merged;
        ppn        <= memData[31:8];
        cacheable  <= memData[7];
        modified   <= memData[6] | storeReg;
        referenced <= 1'b1;
        acc        <= memData[4:2];
        level      <= lvlReg;
        fault      <= FT_NONE;
      end else if (strobe.takeFault) begin
        physAddr <= '0; ppn <= '0; cacheable <= 1'b0;
        modified <= 1'b0; referenced <= 1'b0; acc <= '0;
        level    <= lvlReg;
        fault    <= strobe.faultCode;
      end
    end
  end

  assign memAddr = addrReg;
  assign curLvl  = lvlReg;
endmodule

// File: rtl/table_walker.sv
module table_walker
  import walk_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       vaddr,
  input  logic [CTX_W-1:0]  ctxNum,
  input  logic [31:0]       ctxPtr,
  input  logic              isStore,
  output logic              memReq,
  output logic [31:0]       memAddr,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [31:0]       memData,
  output logic              busy,
  output logic              done,
  output logic [31:0]       physAddr,
  output logic [23:0]       ppn,
  output logic              cacheable,
  output logic              modified,
  output logic              referenced,
  output logic [2:0]        acc,
  output logic [1:0]        level,
  output logic [2:0]        fault
);
  walkStrobe_t strobe;
  logic [1:0]  curLvl;

  walk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .memAck(memAck), .memErr(memErr),
    .descType(memData[1:0]), .curLvl(curLvl), .strobe(strobe),
    .memReq(memReq), .busy(busy)
  );

  walk_datapath #(.CTX_W(CTX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .vaddr(vaddr), .ctxNum(ctxNum),
    .ctxPtr(ctxPtr), .isStore(isStore), .memData(memData), .memAddr(memAddr),
    .curLvl(curLvl), .done(done), .physAddr(physAddr), .ppn(ppn),
    .cacheable(cacheable), .modified(modified), .referenced(referenced),
    .acc(acc), .level(level), .fault(fault)
  );
endmodule

// File: rtl/walk_chk.sv
module walk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        memReq,
  input logic        memAck,
  input logic        memErr,
  input logic [31:0] memData,
  input logic [31:0] memAddr,
  input logic        busy,
  input logic        done,
  input logic [2:0]  fault,
  input logic [31:0] physAddr,
  input logic [23:0] ppn,
  input logic        referenced
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq && $stable(memAddr));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 3'b000 |-> referenced);
  // R11
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault != 3'b000 |-> physAddr == 32'd0 && ppn == 24'd0 && !referenced);
  // R9
  bus_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memAck && memErr |=> done && fault == 3'b101);
  // R7
  inv_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memAck && !memErr && memData[1:0] == 2'b00 |=> done && fault == 3'b001);
  // R8
  rsv_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memAck && !memErr && memData[1:0] == 2'b11 |=> done && fault == 3'b110);
endmodule

bind table_walker walk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .memReq(memReq), .memAck(memAck), .memErr(memErr),
  .memData(memData), .memAddr(memAddr), .busy(busy), .done(done), .fault(fault),
  .physAddr(physAddr), .ppn(ppn), .referenced(referenced)
);

// File: tb/table_walker_tb.sv
module table_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic [7:0]  ctxNum = '0;
  logic [31:0] ctxPtr = '0;
  logic        isStore = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;
  logic [31:0] memData = '0;
  logic        busy, done, cacheable, modified, referenced;
  logic [31:0] physAddr;
  logic [23:0] ppn;
  logic [2:0]  acc, fault;
  logic [1:0]  level;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  table_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .ctxNum(ctxNum),
    .ctxPtr(ctxPtr), .isStore(isStore), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memErr(memErr), .memData(memData), .busy(busy), .done(done),
    .physAddr(physAddr), .ppn(ppn), .cacheable(cacheable), .modified(modified),
    .referenced(referenced), .acc(acc), .level(level), .fault(fault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      testsFailed = testsFailed + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun = testsRun + 1;
    if (!ok) begin
      testsFailed = testsFailed + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ptrAt(input int s);
    return 32'h0040_0000 + (32'(s) << 16);
  endfunction

  // kind: 0 entry, 1 invalid, 2 reserved, 3 descriptor at level 3, 4 bus error
  task automatic runWalk(input logic [31:0] va, input logic [7:0] ctx, input logic [31:0] cp,
                         input bit st, input int endLvl, input int kind, input int lat);
    logic [31:0] expAddr, pte, word, expPa, mask, heldPa;
    logic [2:0]  expFault;
    int          lowBits;
    pte = {va[31:8] ^ 24'h5A3C96, va[0], va[1], 1'b0, va[4:2], 2'b10};
    @(negedge clk);
    vaddr = va; ctxNum = ctx; ctxPtr = cp; isStore = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s <= endLvl; s++) begin
      if (s == 0) expAddr = {cp[31:2], 2'b00} + {22'd0, ctx, 2'b00};
      else if (s == 1) expAddr = ptrAt(0) + {22'd0, va[31:24], 2'b00};
      else if (s == 2) expAddr = ptrAt(1) + {24'd0, va[23:18], 2'b00};
      else expAddr = ptrAt(2) + {24'd0, va[17:12], 2'b00};
      check(memReq === 1'b1, "R2 request raised", {31'd0, memReq}, 32'd1);
      check(memAddr === expAddr, s == 0 ? "R2 first address" : "R3 next address", memAddr, expAddr);
      for (int k = 0; k < lat; k++) begin
        if (k == 0 && s == 0) begin start = 1'b1; vaddr = ~va; ctxNum = ~ctx; end
        @(negedge clk);
        start = 1'b0; vaddr = va; ctxNum = ctx;
        check(memReq === 1'b1 && memAddr === expAddr, "R2 R10 hold while waiting", memAddr, expAddr);
      end
      memAck = 1'b1; memErr = 1'b0;
      if (s < endLvl) word = {ptrAt(s)[31:2], 2'b01};
      else begin
        case (kind)
          0: word = pte;
          1: word = {va[31:2], 2'b00};
          2: word = {va[31:2], 2'b11};
          3: word = {ptrAt(s)[31:2], 2'b01};
          default: begin word = pte; memErr = 1'b1; end
        endcase
      end
      memData = word;
      @(negedge clk);
      memAck = 1'b0; memErr = 1'b0; memData = 32'hDEAD_BEEF;
    end
    case (kind)
      0: expFault = 3'b000;
      1: expFault = 3'b001;
      4: expFault = 3'b101;
      default: expFault = 3'b110;
    endcase
    lowBits = (endLvl == 0) ? 32 : (endLvl == 1) ? 24 : (endLvl == 2) ? 18 : 12;
    mask = (lowBits == 32) ? 32'hFFFF_FFFF : ((32'd1 << lowBits) - 32'd1);
    expPa = ((pte << 4) & ~mask) | (va & mask);
    check(done === 1'b1 && busy === 1'b0, "R10 done pulse", {31'd0, done}, 32'd1);
    check(level === 2'(endLvl), "R5 level", {30'd0, level}, 32'(endLvl));
    if (kind == 0) begin
      check(fault === 3'b000, "R6 no fault", {29'd0, fault}, 32'd0);
      check(physAddr === expPa, "R4 merged address", physAddr, expPa);
      check(ppn === pte[31:8] && cacheable === pte[7] && acc === pte[4:2],
            "R6 entry fields", {ppn, cacheable, 4'd0, acc}, {pte[31:8], pte[7], 4'd0, pte[4:2]});
      check(referenced === 1'b1 && modified === (pte[6] | st), "R6 ref/mod",
            {30'd0, referenced, modified}, {30'd0, 1'b1, pte[6] | st});
    end else begin
      check(fault === expFault, kind == 1 ? "R7 invalid fault" : kind == 4 ? "R9 bus fault" : "R8 translation fault",
            {29'd0, fault}, {29'd0, expFault});
      check(physAddr === 32'd0 && ppn === 24'd0 && referenced === 1'b0 && modified === 1'b0 &&
            cacheable === 1'b0 && acc === 3'd0, "R11 cleared fields", physAddr, 32'd0);
    end
    heldPa = physAddr;
    @(negedge clk);
    check(done === 1'b0 && memReq === 1'b0, "R10 single pulse", {31'd0, done}, 32'd0);
    check(physAddr === heldPa, "R10 result held", physAddr, heldPa);
  endtask

  initial begin
    logic [31:0] vas [3];
    vas[0] = 32'h1234_5678; vas[1] = 32'hFEDC_BA9B; vas[2] = 32'h00FF_F00E;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && memReq === 1'b0, "R1 reset controls",
          {29'd0, busy, done, memReq}, 32'd0);
    check(fault === 3'b000 && level === 2'b00, "R1 reset codes", {27'd0, fault, level}, 32'd0);
    rst_n = 1'b1;
    for (int e = 0; e < 4; e++)
      for (int kd = 0; kd < 5; kd++)
        for (int st = 0; st < 2; st++)
          for (int v = 0; v < 3; v++) begin
            if (kd == 3 && e != 3) continue;
            runWalk(vas[v], 8'(v * 37 + e * 11 + 200), 32'h0080_0003 + 32'(v << 12),
                    st[0], e, kd, (v + st) % 3);
          end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule